// File: doc/BRIEF.md
# Station Address Boot Loader

This block fetches the 48-bit station address from a word-addressed serial EEPROM when the chip comes out of reset. It does not drive the serial wires. Instead it asks a separate EEPROM read engine for one 16-bit word at a time, using a request/done handshake. The first word it reads is a signature. When the signature is correct, the block reads three further words and assembles six address bytes from them. It then runs a validity check on the address and, only if the check passes, commits the address to its output register.

The sequence starts by itself once reset is released, and it can be run again with a single-cycle start pulse whenever the block is idle. Every run ends with a one-cycle completion pulse, whichever path it took. At that point exactly one of three status flags tells the outcome: address loaded, signature missing, or address invalid.

Top module: `mac_addr_loader`

## Requirements
- R1: Once reset is released, the block issues its first read request without any start pulse. That request targets word address 0. While idle, a one-cycle `start` pulse begins a new sequence, again with word 0.
- R2: If word 0 is not 16'h8129, the sequence ends with `sig_missing` set. No further read request is made and `mac_addr` does not change.
- R3: If word 0 equals 16'h8129, the block requests word addresses 7, 8 and 9, strictly in that order.
- R4: Byte k of the address is placed on `mac_addr[8k+7:8k]`. Word 7 supplies bytes 0 (its bits 7:0) and 1 (its bits 15:8). Word 8 supplies bytes 2 and 3. Word 9 supplies bytes 4 and 5.
- R5: The assembled address is valid when it is not all zeros and its bit 0 (the group bit of byte 0) is clear. A valid address is written to `mac_addr` and sets `mac_loaded`.
- R6: An invalid address sets `addr_invalid` and leaves `mac_addr` unchanged. At most one of `mac_loaded`, `sig_missing` and `addr_invalid` is ever high.
- R7: `rd_req` is high for a single cycle per word. No new request is made until `rd_done` has returned for the previous one. A `rd_done` that arrives while no read is outstanding is ignored.
- R8: `seq_done` pulses high for exactly one cycle at the end of every sequence, whichever path it took.
- R9: Reset clears `mac_addr` to all zeros and clears all status flags.
- R10: A `start` pulse that arrives while a sequence is running is ignored. A `start` accepted while idle clears the three status flags but keeps `mac_addr` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to rerun the load while idle |
| rd_req | output | 1 | One-cycle word read request to the EEPROM engine |
| rd_addr | output | ADDR_W | Word address of the current request |
| rd_done | input | 1 | One-cycle pulse: read finished, rd_data valid |
| rd_data | input | 16 | Word returned by the read engine |
| mac_addr | output | 48 | Committed station address, byte k on bits 8k+7:8k |
| mac_loaded | output | 1 | Last sequence committed an address |
| sig_missing | output | 1 | Last sequence found a wrong signature |
| addr_invalid | output | 1 | Last sequence read an invalid address |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench builds the block with its default parameters: an 8-bit word address, signature 16'h8129 at word 0, and the address block starting at word 7. Its EEPROM model holds 16 words, which covers every address the sequencer can request. The model's response latency can be changed between runs. This makes it possible to hold the engine busy long enough to place a second start pulse inside a running sequence, and to deliver a stray done pulse while idle. One run deliberately passes through each outcome: a committed address, a set group bit, an all-zero address and a wrong signature. Because the earlier address must survive the runs that follow it, the tests also confirm that the output register does not change on the failing paths.

// File: rtl/mac_addr_loader.sv
module mac_addr_loader #(
  parameter int          ADDR_W   = 8,
  parameter logic [15:0] SIG_WORD = 16'h8129,
  parameter int          SIG_ADDR = 0,
  parameter int          MAC_BASE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  input  logic [15:0]       rd_data,
  output logic [47:0]       mac_addr,
  output logic              mac_loaded,
  output logic              sig_missing,
  output logic              addr_invalid,
  output logic              seq_done
);

  localparam int MAC_WORDS = 3;

  typedef enum logic [2:0] {S_BOOT, S_IDLE, S_REQ, S_WAIT, S_CHECK, S_END} state_t;

  state_t      state;
  logic [1:0]  idx;
  logic [47:0] shadow;
  logic        shadow_ok;

  assign rd_req    = (state == S_REQ);
  assign seq_done  = (state == S_END);
  assign rd_addr   = (idx == 2'd0) ? ADDR_W'(SIG_ADDR) : ADDR_W'(MAC_BASE + int'(idx) - 1);
  assign shadow_ok = (shadow != '0) && !shadow[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_BOOT;
      idx          <= '0;
      shadow       <= '0;
      mac_addr     <= '0;
      mac_loaded   <= 1'b0;
      sig_missing  <= 1'b0;
      addr_invalid <= 1'b0;
    end else begin
      case (state)
        S_BOOT: begin
          idx   <= '0;
          state <= S_REQ;
        end
        S_IDLE: begin
          if (start) begin
            idx          <= '0;
            mac_loaded   <= 1'b0;
            sig_missing  <= 1'b0;
            addr_invalid <= 1'b0;
            state        <= S_REQ;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: begin
          if (rd_done) begin
            if (idx == 2'd0) begin
              if (rd_data != SIG_WORD) begin
                sig_missing <= 1'b1;
                state       <= S_END;
              end else begin
                idx   <= 2'd1;
                state <= S_REQ;
              end
            end else begin
              shadow[(int'(idx) - 1) * 16 +: 16] <= rd_data;
              if (int'(idx) == MAC_WORDS) begin
                state <= S_CHECK;
              end else begin
                idx   <= idx + 2'd1;
                state <= S_REQ;
              end
            end
          end
        end
        S_CHECK: begin
          if (shadow_ok) begin
            mac_addr   <= shadow;
            mac_loaded <= 1'b1;
          end else begin
            addr_invalid <= 1'b1;
          end
          state <= S_END;
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R7

  AST_NO_REQ_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    sig_missing |-> !rd_req); // R2

  AST_MISS_KEEPS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_missing) |-> $stable(mac_addr)); // R2

  AST_COMMIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mac_addr) |-> (mac_addr != '0 && !mac_addr[0] && mac_loaded)); // R5

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mac_loaded, sig_missing, addr_invalid})); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done); // R8

endmodule

// File: tb/test_mac_addr_loader.sv
`timescale 1ns/1ps
module test_mac_addr_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_done = 1'b0;
  logic [15:0] rd_data = '0;
  logic [47:0] mac_addr;
  logic        mac_loaded, sig_missing, addr_invalid, seq_done;

  always #2.5 clk = ~clk;

  mac_addr_loader i_mac_addr_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .mac_addr(mac_addr), .mac_loaded(mac_loaded), .sig_missing(sig_missing),
    .addr_invalid(addr_invalid), .seq_done(seq_done)
  );

  logic [15:0] mem [16];
  int          lat = 2;
  logic [7:0]  exp_addr_q[$];
  logic [50:0] exp_res_q[$];
  int          checks = 0;
  int          fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // EEPROM model: checks each requested address against the scoreboard (R1 R3 R7)
  initial begin
    @(negedge clk);
    forever begin
      if (rst_n && rd_req) begin
        logic [7:0] a;
        a = rd_addr;
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R2/R7 unexpected request", 64'(a), 64'hFF);
        end else begin
          logic [7:0] e;
          e = exp_addr_q.pop_front();
          chk(a == e, "R3 request address order", 64'(a), 64'(e));
        end
        repeat (lat) @(negedge clk);
        rd_data = mem[a[3:0]];
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Result monitor (R2 R4 R5 R6 R8)
  initial forever begin
    @(negedge clk);
    if (rst_n && seq_done) begin
      if (exp_res_q.size() == 0) begin
        chk(1'b0, "R8 extra done pulse", 64'(seq_done), 64'h0);
      end else begin
        logic [50:0] e;
        e = exp_res_q.pop_front();
        chk({mac_addr, mac_loaded, sig_missing, addr_invalid} == e, "R4/R5/R6 result",
            64'({mac_addr, mac_loaded, sig_missing, addr_invalid}), 64'(e));
        chk(exp_addr_q.size() == 0, "R2 requests left unissued", 64'(exp_addr_q.size()), 64'h0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_empty();
    while (exp_res_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic push_full(input logic [47:0] m, input bit ld, input bit miss, input bit inv);
    exp_addr_q.push_back(8'd0);
    if (!miss) begin
      exp_addr_q.push_back(8'd7);
      exp_addr_q.push_back(8'd8);
      exp_addr_q.push_back(8'd9);
    end
    exp_res_q.push_back({m, ld, miss, inv});
  endtask

  logic [47:0] last_mac;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
    // Case A: auto-load after reset, valid address (R1 R3 R4 R5 R9)
    mem[0] = 16'h8129; mem[7] = 16'h3402; mem[8] = 16'h7856; mem[9] = 16'hBC9A;
    last_mac = 48'hBC9A_7856_3402;
    repeat (4) @(negedge clk);
    chk({mac_addr, mac_loaded, sig_missing, addr_invalid} == '0, "R9 reset state",
        64'({mac_addr, mac_loaded, sig_missing, addr_invalid}), 64'h0);
    push_full(last_mac, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mac_addr == '0 && !mac_loaded, "R9 address zero before load", 64'(mac_addr), 64'h0);
    wait_empty();

    // Case B: group bit set -> invalid, address kept (R6)
    mem[7] = 16'h3401;
    push_full(last_mac, 1'b0, 1'b0, 1'b1);
    pulse_start();
    wait_empty();

    // Case C: all-zero address -> invalid (R5 R6)
    mem[7] = 16'h0000; mem[8] = 16'h0000; mem[9] = 16'h0000;
    push_full(last_mac, 1'b0, 1'b0, 1'b1);
    pulse_start();
    wait_empty();

    // Case D: wrong signature -> stop after word 0 (R2)
    mem[0] = 16'h2981;
    push_full(last_mac, 1'b0, 1'b1, 1'b0);
    pulse_start();
    wait_empty();
    chk(sig_missing == 1'b1, "R2 flag held after end", 64'(sig_missing), 64'h1);

    // Case E: new valid address, slow engine, extra start while busy (R10 R5)
    lat = 6;
    mem[0] = 16'h8129; mem[7] = 16'h1100;
    last_mac = 48'h0000_0000_1100;
    push_full(last_mac, 1'b1, 1'b0, 1'b0);
    pulse_start();
    chk(!sig_missing && !mac_loaded && !addr_invalid, "R10 start clears flags",
        64'({mac_loaded, sig_missing, addr_invalid}), 64'h0);
    chk(mac_addr == 48'hBC9A_7856_3402, "R10 start keeps address", 64'(mac_addr), 64'hBC9A_7856_3402);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_empty();
    chk(mac_addr == last_mac, "R10 busy start ignored", 64'(mac_addr), 64'(last_mac));

    // Case F: stray done while idle is ignored (R7)
    @(negedge clk);
    rd_data = 16'h0002;
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    repeat (5) @(negedge clk);
    chk(mac_addr == last_mac && mac_loaded, "R7 stray done ignored",
        64'({mac_addr, mac_loaded}), 64'({last_mac, 1'b1}));
    chk(exp_res_q.size() == 0, "R8 no extra sequence", 64'(exp_res_q.size()), 64'h0);

    summary();
    $finish;
  end
endmodule